// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Unit

This block is a 32-pin general-purpose I/O bank for a larger chip. Software reaches it over a simple register bus with one-cycle accesses: an address, write data, a write strobe, a read strobe and read data that is valid in the same cycle as the read strobe. The bank drives a pad output vector and a pad output-enable vector. It samples a pad input vector through a two-flop synchronizer. Every pin can also act as an interrupt source, and the bank merges all of its pending, enabled interrupts into one line.

There are eight register blocks, each 16 bytes apart, with one bit per pin. Inside a block the byte offset chooses the access. Offset 0x0 loads the whole word. Offset 0x4 sets the bits that are 1 in the write data. Offset 0x8 clears the bits that are 1 in the write data. In both alias cases all other bits keep their value, so any agent can update single bits without a read-modify-write. Each pin has a trigger made of two bits: a level/edge bit and a polarity bit. Pending bits are sticky. Software can remove a pending bit only by writing to the clear alias of that block. Both-edge triggering is left to software, which can flip a pin's polarity after each event.

Top module: `gpio_bank_ctl`

## Requirements
- R1: After reset, pad_out, pad_oe and irq are 0, and every writable block reads back 0. The blocks are output value 0x00, drive enable 0x20, interrupt route 0x30, interrupt mask 0x40, trigger level 0x50, trigger polarity 0x60 and pending 0x70.
- R2: In each block, a write at offset 0x0 loads the word, a write at 0x4 ORs in the data, and a write at 0x8 clears the bits that are 1 in the data. A write at offset 0xC, or at any address whose bits [1:0] are not 00, changes nothing.
- R3: pad_out always equals the output value block, and pad_oe always equals the drive enable block. A 1 in drive enable means the pin is driven.
- R4: The input block (0x10) returns pad_in as sampled two clock edges earlier. Writes to it have no effect on the bank.
- R5: With its level bit at 0, a routed pin registers a rising edge when its polarity bit is 1 and a falling edge when its polarity bit is 0. The pending bit is readable 3 edges after the pad changes and is not yet set after 2 edges. An edge of the opposite direction sets nothing.
- R6: With its level bit at 1, a routed pin sets its pending bit on every cycle in which the synchronized level equals its polarity bit. A clear while the level is active therefore leaves the bit at 1. Once the level has gone inactive, a clear removes the bit.
- R7: A pin whose route bit is 0 never sets its pending bit.
- R8: A pending bit falls only through a write of 1 at the pending block's clear alias (0x78). Load writes and set-alias writes to the pending block change nothing. A hardware event wins over a clear in the same cycle.
- R9: irq is 1 exactly when some bit is set in both pending and mask. Changing the mask does not change pending.
- R10: With bus_rd low, bus_rdata is 0. A read returns the selected block at any offset within it. Addresses with bit 7 set read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational from address while bus_rd is high |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables, 1 drives |
| irq | output | 1 | Combined bank interrupt |

## Verification
The assertions assume that a bus write lasts one cycle with a stable address. They also assume that a pending bit can be set only by an event computed in the cycle before, from the route, level and polarity registers and the synchronized pad values. The bench drives every bus signal and pad on the falling clock edge and pulses bus_wr for exactly one cycle. It changes pads only while no bus write targets a trigger register, so each event can be traced to one synchronized transition. Pad transitions are spaced at least two edges apart, so the synchronizer never sees two changes that overlap.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int BLK_N = 8;
    localparam int BLK_W = 3;
    localparam int OFS_W = 4;

    // block index = address bits [6:4]
    typedef enum logic [2:0] {
        BLK_OUT   = 3'd0,
        BLK_IN    = 3'd1,
        BLK_DRV   = 3'd2,
        BLK_ROUTE = 3'd3,
        BLK_MASK  = 3'd4,
        BLK_LVL   = 3'd5,
        BLK_POL   = 3'd6,
        BLK_PEND  = 3'd7
    } blk_e;

    // access kind = address bits [3:2]
    typedef enum logic [1:0] {
        ACC_LOAD = 2'd0,
        ACC_SET  = 2'd1,
        ACC_CLR  = 2'd2,
        ACC_NONE = 2'd3
    } acc_e;

    // {polarity, level}
    typedef enum logic [1:0] {
        TRIG_FALL = 2'b00,
        TRIG_LOW  = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_HIGH = 2'b11
    } trig_e;

endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output blk_e              blk,
    output logic              hit,
    output acc_e              acc,
    output logic [BLK_N-1:0]  wr_blk
);
    localparam int TOP_LSB = OFS_W + BLK_W;

    always_comb begin
        blk = blk_e'(addr[TOP_LSB-1:OFS_W]);
        hit = (addr[ADDR_W-1:TOP_LSB] == '0);
        if (addr[1:0] != 2'b00) begin
            acc = ACC_NONE;
        end else begin
            acc = acc_e'(addr[OFS_W-1:OFS_W-2]);
        end
        wr_blk = '0;
        if (wr && hit && (acc != ACC_NONE)) begin
            wr_blk[blk] = 1'b1;
        end
    end

endmodule

// File: rtl/gpio_cfg_reg.sv
module gpio_cfg_reg
    import gpio_bank_pkg::*;
#(
    parameter int N       = 32,
    parameter bit LOAD_OK = 1'b1,
    parameter bit SET_OK  = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  acc_e         acc,
    input  logic [N-1:0] wdata,
    input  logic [N-1:0] hw_set,
    output logic [N-1:0] q
);
    logic [N-1:0] nxt;

    always_comb begin
        nxt = q;
        if (wr_en) begin
            unique case (acc)
                ACC_LOAD: if (LOAD_OK) nxt = wdata;
                ACC_SET:  if (SET_OK)  nxt = q | wdata;
                ACC_CLR:  nxt = q & ~wdata;
                default:  nxt = q;
            endcase
        end
        // hardware events win over a same-cycle clear
        nxt = nxt | hw_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

    // R8: a bit may only fall after a clear-alias write (or a load where allowed)
    a_r8_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(q) & ~q) != '0) |->
            $past(wr_en && ((acc == ACC_CLR) || (LOAD_OK && (acc == ACC_LOAD)))));

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pad,
    output logic [N-1:0] cur,
    output logic [N-1:0] prev
);
    logic [N-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            cur  <= '0;
            prev <= '0;
        end else begin
            meta <= pad;
            cur  <= meta;
            prev <= cur;
        end
    end

endmodule

// File: rtl/gpio_trigger.sv
module gpio_trigger
    import gpio_bank_pkg::*;
#(
    parameter int N = 32
) (
    input  logic [N-1:0] cur,
    input  logic [N-1:0] prev,
    input  logic [N-1:0] route,
    input  logic [N-1:0] lvl,
    input  logic [N-1:0] pol,
    output logic [N-1:0] evt
);
    for (genvar p = 0; p < N; p++) begin : g_pin
        trig_e mode;
        logic  fire;

        always_comb begin
            mode = trig_e'({pol[p], lvl[p]});
            unique case (mode)
                TRIG_FALL: fire = prev[p] & ~cur[p];
                TRIG_RISE: fire = cur[p] & ~prev[p];
                TRIG_LOW:  fire = ~cur[p];
                TRIG_HIGH: fire = cur[p];
                default:   fire = 1'b0;
            endcase
            evt[p] = route[p] & fire;
        end
    end

endmodule

// File: rtl/gpio_bank_ctl.sv
module gpio_bank_ctl
    import gpio_bank_pkg::*;
#(
    parameter int N      = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N-1:0]      bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [N-1:0]      bus_rdata,
    input  logic [N-1:0]      pad_in,
    output logic [N-1:0]      pad_out,
    output logic [N-1:0]      pad_oe,
    output logic              irq
);
    blk_e                      blk;
    logic                      hit;
    acc_e                      acc;
    logic [BLK_N-1:0]          wr_blk;
    logic [N-1:0]              cur;
    logic [N-1:0]              prev;
    logic [N-1:0]              evt;
    logic [BLK_N-1:0][N-1:0]   regs;

    gpio_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr   (bus_addr),
        .wr     (bus_wr),
        .blk    (blk),
        .hit    (hit),
        .acc    (acc),
        .wr_blk (wr_blk)
    );

    gpio_in_sync #(.N(N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pad   (pad_in),
        .cur   (cur),
        .prev  (prev)
    );

    gpio_trigger #(.N(N)) u_trig (
        .cur   (cur),
        .prev  (prev),
        .route (regs[BLK_ROUTE]),
        .lvl   (regs[BLK_LVL]),
        .pol   (regs[BLK_POL]),
        .evt   (evt)
    );

    for (genvar b = 0; b < BLK_N; b++) begin : g_blk
        if (b == int'(BLK_IN)) begin : g_in
            assign regs[b] = cur;
        end else begin : g_reg
            localparam bit IS_PEND = (b == int'(BLK_PEND));
            gpio_cfg_reg #(
                .N       (N),
                .LOAD_OK (!IS_PEND),
                .SET_OK  (!IS_PEND)
            ) u_reg (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_en  (wr_blk[b]),
                .acc    (acc),
                .wdata  (bus_wdata),
                .hw_set (IS_PEND ? evt : {N{1'b0}}),
                .q      (regs[b])
            );
        end
    end

    assign pad_out   = regs[BLK_OUT];
    assign pad_oe    = regs[BLK_DRV];
    assign irq       = |(regs[BLK_PEND] & regs[BLK_MASK]);
    assign bus_rdata = (bus_rd && hit) ? regs[blk] : {N{1'b0}};

    // R2: pad outputs change only after a bus write
    a_r2_pad_out_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pad_out) |-> $past(bus_wr));

    // R4: a write aimed at the input block leaves the pad controls alone
    a_r4_in_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        wr_blk[BLK_IN] |=> ($stable(pad_out) && $stable(pad_oe)));

    // R7: no pending bit rises on an unrouted pin
    a_r7_route_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ((regs[BLK_PEND] & ~$past(regs[BLK_PEND]) & ~$past(regs[BLK_ROUTE])) == '0));

    // R6: an active routed level leaves its pending bit set on the next cycle
    a_r6_level_refire: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(regs[BLK_ROUTE] & regs[BLK_LVL] & ~(cur ^ regs[BLK_POL]))
          & ~regs[BLK_PEND]) == '0));

endmodule

// File: tb/sim_gpio_bank_ctl.sv
module sim_gpio_bank_ctl;
    localparam int N  = 32;
    localparam int AW = 8;
    localparam logic [7:0] A_OUT = 8'h00, A_IN = 8'h10, A_DRV = 8'h20, A_ROUTE = 8'h30;
    localparam logic [7:0] A_MASK = 8'h40, A_LVL = 8'h50, A_POL = 8'h60, A_PEND = 8'h70;
    localparam logic [7:0] O_SET = 8'h04, O_CLR = 8'h08;

    logic          clk, rst_n, bus_wr, bus_rd, irq;
    logic [AW-1:0] bus_addr;
    logic [N-1:0]  bus_wdata, bus_rdata, pad_in, pad_out, pad_oe;
    int            n_chk = 0, n_fail = 0;
    bit            done = 0;

    gpio_bank_ctl #(.N(N), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic settle(input int k);
        repeat (k) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bwr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
        #1;
    endtask

    task automatic expect_reg(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        brd(a, d);
        check(tag, d, exp);
    endtask

    task automatic t_reset;
        check("R1 pad_out", pad_out, 0);
        check("R1 pad_oe", pad_oe, 0);
        check("R1 irq", {31'd0, irq}, 0);
        expect_reg("R1 out", A_OUT, 0);
        expect_reg("R1 drv", A_DRV, 0);
        expect_reg("R1 route", A_ROUTE, 0);
        expect_reg("R1 mask", A_MASK, 0);
        expect_reg("R1 lvl", A_LVL, 0);
        expect_reg("R1 pol", A_POL, 0);
        expect_reg("R1 pend", A_PEND, 0);
    endtask

    task automatic t_alias;
        bwr(A_OUT, 32'hA5A5_0F0F);
        expect_reg("R2 load", A_OUT, 32'hA5A5_0F0F);
        bwr(A_OUT | O_SET, 32'h0000_00F0);
        expect_reg("R2 set", A_OUT, 32'hA5A5_0FFF);
        bwr(A_OUT | O_CLR, 32'hA500_0000);
        expect_reg("R2 clr", A_OUT, 32'h00A5_0FFF);
        bwr(A_OUT | 8'h0C, 32'hFFFF_FFFF);
        bwr(A_OUT | 8'h01, 32'h0000_0000);
        expect_reg("R2 odd offset", A_OUT, 32'h00A5_0FFF);
        check("R3 pad_out", pad_out, 32'h00A5_0FFF);
        bwr(A_DRV | O_SET, 32'h0000_FFFF);
        bwr(A_DRV | O_CLR, 32'h0000_00FF);
        check("R3 pad_oe", pad_oe, 32'h0000_FF00);
    endtask

    task automatic t_input;
        pad_in = 32'h1234_5678;
        settle(1);
        expect_reg("R4 one edge", A_IN, 0);
        settle(1);
        expect_reg("R4 two edges", A_IN, 32'h1234_5678);
        bwr(A_IN, 32'h0);
        bwr(A_IN | O_SET, 32'hFFFF_FFFF);
        expect_reg("R4 write ignored", A_IN, 32'h1234_5678);
        check("R4 pad_out kept", pad_out, 32'h00A5_0FFF);
        check("R4 pad_oe kept", pad_oe, 32'h0000_FF00);
        pad_in = 0;
        settle(2);
    endtask

    task automatic t_edge;
        bwr(A_ROUTE | O_SET, 32'h3);
        bwr(A_POL | O_SET, 32'h1);
        pad_in = 32'h1;
        settle(2);
        expect_reg("R5 rise not yet", A_PEND, 0);
        settle(1);
        expect_reg("R5 rise seen", A_PEND, 32'h1);
        bwr(A_PEND | O_CLR, 32'h1);
        expect_reg("R5 cleared", A_PEND, 0);
        pad_in = 32'h3;
        settle(4);
        expect_reg("R5 wrong direction", A_PEND, 0);
        pad_in = 32'h0;
        settle(3);
        expect_reg("R5 fall seen", A_PEND, 32'h2);
        bwr(A_PEND | O_CLR, 32'hFFFF_FFFF);
    endtask

    task automatic t_route;
        bwr(A_POL | O_SET, 32'h4);
        pad_in = 32'h4;
        settle(4);
        expect_reg("R7 unrouted", A_PEND, 0);
        pad_in = 32'h0;
        settle(2);
    endtask

    task automatic t_level;
        bwr(A_ROUTE | O_SET, 32'h8);
        bwr(A_LVL | O_SET, 32'h8);
        bwr(A_POL | O_SET, 32'h8);
        pad_in = 32'h8;
        settle(3);
        expect_reg("R6 level set", A_PEND, 32'h8);
        bwr(A_PEND | O_CLR, 32'h8);
        expect_reg("R6 clear overridden", A_PEND, 32'h8);
        pad_in = 32'h0;
        settle(2);
        bwr(A_PEND | O_CLR, 32'h8);
        expect_reg("R6 clear after release", A_PEND, 0);
        settle(2);
        expect_reg("R6 stays clear", A_PEND, 0);
    endtask

    task automatic t_pend_write;
        pad_in = 32'h1;
        settle(3);
        expect_reg("R8 setup", A_PEND, 32'h1);
        bwr(A_PEND, 32'h0);
        expect_reg("R8 load ignored", A_PEND, 32'h1);
        bwr(A_PEND | O_SET, 32'hF0);
        expect_reg("R8 set ignored", A_PEND, 32'h1);
    endtask

    task automatic t_irq;
        check("R9 mask off", {31'd0, irq}, 0);
        bwr(A_MASK | O_SET, 32'h20);
        check("R9 other bit", {31'd0, irq}, 0);
        bwr(A_MASK | O_SET, 32'h1);
        check("R9 raised", {31'd0, irq}, 1);
        bwr(A_MASK | O_CLR, 32'h1);
        check("R9 masked", {31'd0, irq}, 0);
        expect_reg("R9 pend kept", A_PEND, 32'h1);
        bwr(A_MASK | O_SET, 32'h1);
        bwr(A_PEND | O_CLR, 32'h1);
        check("R9 cleared", {31'd0, irq}, 0);
    endtask

    task automatic t_read;
        bus_addr = A_OUT; bus_rd = 1'b0;
        #1 check("R10 idle zero", bus_rdata, 0);
        expect_reg("R10 alias read", A_OUT | O_CLR, 32'h00A5_0FFF);
        bwr(8'h80, 32'h0);
        check("R10 unmapped write", pad_out, 32'h00A5_0FFF);
        expect_reg("R10 unmapped read", 8'h80, 0);
    endtask

    initial begin
        rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
        bus_addr = '0; bus_wdata = '0; pad_in = '0;
        settle(3);
        rst_n = 1'b1;
        settle(1);
        t_reset();
        t_alias();
        t_input();
        t_edge();
        t_route();
        t_level();
        t_pend_write();
        t_irq();
        t_read();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule